// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block sits between the software-facing transmit mailboxes of a CAN controller and its protocol engine. It holds four transmit mailboxes (global mailbox numbers 12 to 15; local index 0 to 3 on the configuration port). Each mailbox stores a mode, a 4-bit priority, an identifier word, a DLC, a remote-request flag and eight data bytes. Software fills a mailbox over a simple write port and then launches it with a transfer command. Whenever the engine is idle, the arbiter picks one pending mailbox and hands its frame to the engine. It then waits for the engine to report success or abort. After that report it updates the mailbox status flags and pulses the interrupt line that belongs to that mailbox.

The selection picks the pending mailbox with the smallest priority value. If several share that value, the lowest mailbox number wins. A frame that has gone to the engine stays there until the engine reports back. A later request with a better priority waits for the next selection. The identifier word can only be changed while its mailbox is in the disabled mode. Software can cancel a queued mailbox that has not yet been handed to the engine.

The `rst_n` input is an asynchronous active-low reset. Its release is expected to be synchronised upstream.

Top module: `tx_prio_arb`

## Requirements
- R1: After reset every mailbox reports ready=1 and aborted=0, no interrupt bit is set, `eng_start` is low, and every mode is disabled (code 0).
- R2: A control write (select 4) with bit 23 set starts a transfer only if the mailbox mode (mode write, select 0, bits 26:24) is transmit (code 3) and its ready flag is 1. The write latches the DLC from bits 19:16 and the remote flag from bit 20, and it clears ready. Otherwise the write is ignored.
- R3: Among pending transmit-mode mailboxes, the one with the numerically smallest priority (mode write bits 19:16, 0 = highest) is handed to the engine first.
- R4: When pending mailboxes share the best priority, the lowest mailbox index is chosen.
- R5: An identifier write (select 1, 32 bits) takes effect only while the mailbox mode is disabled (code 0). In any other mode it is ignored.
- R6: Selection is made only when no frame is in flight. `eng_start` pulses for exactly one cycle, in the cycle after the selecting edge. `eng_mb` and the frame fields then hold until the engine reports done or abort, so no later request preempts the frame.
- R7: An `eng_done` report during a transfer sets that mailbox's ready flag, clears its aborted flag and pulses interrupt bit 12+index for one cycle. The flags and the interrupt bit appear in the same cycle.
- R8: An `eng_abort` report during a transfer sets both the ready and the aborted flag of that mailbox and pulses its interrupt bit.
- R9: A control write with bit 22 set to a pending mailbox that is neither in flight nor being selected at that edge removes it from arbitration. It sets ready and aborted and pulses its interrupt bit. The same write to the in-flight mailbox is ignored.
- R10: An accepted transfer command clears the mailbox's aborted flag.
- R11: Data writes (select 2 = bytes 0..3, select 3 = bytes 4..7) to a pending mailbox are ignored, so the frame sent carries the data present at the transfer command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mb | input | 2 | Local mailbox index of the write |
| cfg_sel | input | 3 | Register select: 0 mode, 1 identifier, 2 data low, 3 data high, 4 control |
| cfg_wdata | input | 32 | Write data |
| eng_start | output | 1 | One-cycle pulse: new frame for the engine |
| eng_mb | output | 2 | Local index of the frame in flight |
| eng_id | output | 32 | Identifier word of the frame in flight |
| eng_dlc | output | 4 | DLC of the frame in flight |
| eng_rtr | output | 1 | Remote-request flag of the frame in flight |
| eng_data | output | 64 | Data bytes of the frame in flight |
| eng_done | input | 1 | Engine reports successful completion |
| eng_abort | input | 1 | Engine reports an aborted transfer |
| mb_ready | output | 4 | Per-mailbox ready flag |
| mb_aborted | output | 4 | Per-mailbox aborted flag |
| irq | output | 16 | Mailbox interrupt pulses, bit = global mailbox number |

## Verification
The checker watches several rules on every cycle. It checks that `eng_start` lasts a single cycle, that the in-flight index holds until a report arrives, and that a launched mailbox is never flagged ready. It also checks that every interrupt or aborted flag comes with ready set, and that each engine report is followed by that mailbox's interrupt. The choice of winner by priority and index, the ignored identifier and data writes, and the cancel-versus-in-flight race depend on the history of writes. Only the bench's reference model and its directed scenarios can show those.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
  localparam int MODE_W = 3;
  localparam int PRIO_W = 4;
  localparam int DLC_W  = 4;

  localparam logic [2:0] SEL_MODE = 3'd0;
  localparam logic [2:0] SEL_ID   = 3'd1;
  localparam logic [2:0] SEL_DLO  = 3'd2;
  localparam logic [2:0] SEL_DHI  = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;

  localparam logic [MODE_W-1:0] MODE_OFF = 3'd0;
  localparam logic [MODE_W-1:0] MODE_TX  = 3'd3;

  localparam int MODE_LSB = 24;
  localparam int PRIO_LSB = 16;
  localparam int DLC_LSB  = 16;
  localparam int RTR_BIT  = 20;
  localparam int ABRQ_BIT = 22;
  localparam int XFER_BIT = 23;

  typedef struct packed {
    logic [31:0]      id;
    logic [DLC_W-1:0] dlc;
    logic             rtr;
    logic [63:0]      data;
  } frame_t;
endpackage

// File: rtl/txarb_pick.sv
module txarb_pick #(
  parameter int N = 4,
  parameter int PW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         elig,
  input  logic [N-1:0][PW-1:0] prio,
  output logic                 any,
  output logic [IW-1:0]        win
);
  logic [PW-1:0] best;

  // strict less-than keeps the earlier (lower) index on a tie
  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!any || (prio[i] < best))) begin
        any  = 1'b1;
        win  = IW'(i);
        best = prio[i];
      end
    end
  end
endmodule

// File: rtl/txarb_sched.sv
module txarb_sched #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any,
  input  logic [IW-1:0] win,
  input  logic          eng_done,
  input  logic          eng_abort,
  output logic          launch,
  output logic          fin,
  output logic          fin_abort,
  output logic          busy,
  output logic [IW-1:0] cur,
  output logic          start
);
  logic          busy_q, busy_d;
  logic [IW-1:0] cur_q, cur_d;
  logic          start_q, start_d;

  assign launch    = !busy_q && any;
  assign fin       = busy_q && (eng_done || eng_abort);
  assign fin_abort = busy_q && eng_abort;

  always_comb begin
    busy_d  = busy_q;
    cur_d   = cur_q;
    start_d = launch;
    if (launch) begin
      busy_d = 1'b1;
      cur_d  = win;
    end else if (fin) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      start_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cur_q   <= cur_d;
      start_q <= start_d;
    end
  end

  assign busy  = busy_q;
  assign cur   = cur_q;
  assign start = start_q;
endmodule

// File: rtl/txarb_bank.sv
module txarb_bank
  import txarb_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [IW-1:0]            cfg_mb,
  input  logic [2:0]               cfg_sel,
  input  logic [31:0]              cfg_wdata,
  input  logic                     busy,
  input  logic [IW-1:0]            cur,
  input  logic                     launch,
  input  logic [IW-1:0]            win,
  input  logic                     fin,
  input  logic                     fin_abort,
  output logic [N-1:0]             elig,
  output logic [N-1:0][PRIO_W-1:0] prio,
  output frame_t [N-1:0]           frames,
  output logic [N-1:0]             ready,
  output logic [N-1:0]             aborted,
  output logic [N-1:0]             irq_loc
);
  for (genvar g = 0; g < N; g++) begin : g_mb
    logic [MODE_W-1:0] mode_q, mode_d;
    logic [PRIO_W-1:0] prio_q, prio_d;
    frame_t            frm_q, frm_d;
    logic              pend_q, pend_d;
    logic              rdy_q, rdy_d;
    logic              abf_q, abf_d;
    logic              irq_q, irq_d;
    logic              hit, own, pick, done_here, xfer, cancel;

    assign hit       = cfg_we && (cfg_mb == IW'(g));
    assign own       = busy && (cur == IW'(g));
    assign pick      = launch && (win == IW'(g));
    assign done_here = fin && (cur == IW'(g));
    assign xfer      = hit && (cfg_sel == SEL_CTRL) && cfg_wdata[XFER_BIT]
                       && (mode_q == MODE_TX) && rdy_q;
    assign cancel    = hit && (cfg_sel == SEL_CTRL) && cfg_wdata[ABRQ_BIT]
                       && pend_q && !own && !pick;

    always_comb begin
      mode_d = mode_q;
      prio_d = prio_q;
      frm_d  = frm_q;
      pend_d = pend_q;
      rdy_d  = rdy_q;
      abf_d  = abf_q;
      irq_d  = done_here || cancel;
      if (hit && (cfg_sel == SEL_MODE)) begin
        mode_d = cfg_wdata[MODE_LSB +: MODE_W];
        prio_d = cfg_wdata[PRIO_LSB +: PRIO_W];
      end
      if (hit && (cfg_sel == SEL_ID) && (mode_q == MODE_OFF))
        frm_d.id = cfg_wdata;
      if (hit && (cfg_sel == SEL_DLO) && !pend_q)
        frm_d.data[31:0] = cfg_wdata;
      if (hit && (cfg_sel == SEL_DHI) && !pend_q)
        frm_d.data[63:32] = cfg_wdata;
      if (xfer) begin
        frm_d.dlc = cfg_wdata[DLC_LSB +: DLC_W];
        frm_d.rtr = cfg_wdata[RTR_BIT];
        pend_d    = 1'b1;
        rdy_d     = 1'b0;
        abf_d     = 1'b0;
      end
      if (cancel) begin
        pend_d = 1'b0;
        rdy_d  = 1'b1;
        abf_d  = 1'b1;
      end
      if (done_here) begin
        pend_d = 1'b0;
        rdy_d  = 1'b1;
        abf_d  = fin_abort;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= MODE_OFF;
        prio_q <= '0;
        frm_q  <= '0;
        pend_q <= 1'b0;
        rdy_q  <= 1'b1;
        abf_q  <= 1'b0;
        irq_q  <= 1'b0;
      end else begin
        mode_q <= mode_d;
        prio_q <= prio_d;
        frm_q  <= frm_d;
        pend_q <= pend_d;
        rdy_q  <= rdy_d;
        abf_q  <= abf_d;
        irq_q  <= irq_d;
      end
    end

    assign elig[g]    = pend_q && (mode_q == MODE_TX);
    assign prio[g]    = prio_q;
    assign frames[g]  = frm_q;
    assign ready[g]   = rdy_q;
    assign aborted[g] = abf_q;
    assign irq_loc[g] = irq_q;
  end
endmodule

// File: rtl/tx_prio_arb.sv
module tx_prio_arb
  import txarb_pkg::*;
#(
  parameter int N = 4,
  parameter int FIRST_MB = 12,
  parameter int TOTAL_MB = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_mb,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic             eng_start,
  output logic [IW-1:0]    eng_mb,
  output logic [31:0]      eng_id,
  output logic [DLC_W-1:0] eng_dlc,
  output logic             eng_rtr,
  output logic [63:0]      eng_data,
  input  logic             eng_done,
  input  logic             eng_abort,
  output logic [N-1:0]     mb_ready,
  output logic [N-1:0]     mb_aborted,
  output logic [TOTAL_MB-1:0] irq
);
  logic [N-1:0]             elig;
  logic [N-1:0][PRIO_W-1:0] prio;
  frame_t [N-1:0]           frames;
  logic [N-1:0]             irq_loc;
  logic                     any, launch, fin, fin_abort, busy;
  logic [IW-1:0]            win, cur;
  frame_t                   sel_frame;

  txarb_bank #(.N(N)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_mb(cfg_mb), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .busy(busy), .cur(cur), .launch(launch), .win(win),
    .fin(fin), .fin_abort(fin_abort),
    .elig(elig), .prio(prio), .frames(frames),
    .ready(mb_ready), .aborted(mb_aborted), .irq_loc(irq_loc)
  );

  txarb_pick #(.N(N), .PW(PRIO_W)) u_pick (
    .elig(elig), .prio(prio), .any(any), .win(win)
  );

  txarb_sched #(.N(N)) u_sched (
    .clk(clk), .rst_n(rst_n), .any(any), .win(win),
    .eng_done(eng_done), .eng_abort(eng_abort),
    .launch(launch), .fin(fin), .fin_abort(fin_abort),
    .busy(busy), .cur(cur), .start(eng_start)
  );

  assign sel_frame = frames[cur];
  assign eng_mb    = cur;
  assign eng_id    = sel_frame.id;
  assign eng_dlc   = sel_frame.dlc;
  assign eng_rtr   = sel_frame.rtr;
  assign eng_data  = sel_frame.data;

  for (genvar b = 0; b < TOTAL_MB; b++) begin : g_irq
    if ((b >= FIRST_MB) && (b < FIRST_MB + N)) begin : g_tx
      assign irq[b] = irq_loc[b - FIRST_MB];
    end else begin : g_other
      assign irq[b] = 1'b0;
    end
  end
endmodule

// File: rtl/tx_prio_arb_chk.sv
module tx_prio_arb_chk #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_start,
  input logic [IW-1:0] eng_mb,
  input logic          eng_done,
  input logic          eng_abort,
  input logic          busy,
  input logic [N-1:0]  mb_ready,
  input logic [N-1:0]  mb_aborted,
  input logic [N-1:0]  irq_loc
);
  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_hold_inflight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done && !eng_abort) |=> (busy && $stable(eng_mb)));

  p_launch_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !mb_ready[eng_mb]);

  p_report_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (eng_done || eng_abort)) |=> irq_loc[$past(eng_mb)]);

  for (genvar i = 0; i < N; i++) begin : g_mb
    p_irq_with_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_loc[i] |-> mb_ready[i]);
    p_abort_with_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mb_aborted[i] |-> mb_ready[i]);
  end
endmodule

bind tx_prio_arb tx_prio_arb_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_mb(eng_mb),
  .eng_done(eng_done), .eng_abort(eng_abort), .busy(busy),
  .mb_ready(mb_ready), .mb_aborted(mb_aborted), .irq_loc(irq_loc)
);

// File: tb/tx_prio_arb_bench.sv
module tx_prio_arb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mb = '0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        eng_done = 1'b0;
  logic        eng_abort = 1'b0;
  logic        eng_start, eng_rtr;
  logic [1:0]  eng_mb;
  logic [31:0] eng_id;
  logic [3:0]  eng_dlc;
  logic [63:0] eng_data;
  logic [3:0]  mb_ready, mb_aborted;
  logic [15:0] irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tx_prio_arb u_tx_prio_arb (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mb(cfg_mb),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .eng_start(eng_start),
    .eng_mb(eng_mb), .eng_id(eng_id), .eng_dlc(eng_dlc), .eng_rtr(eng_rtr),
    .eng_data(eng_data), .eng_done(eng_done), .eng_abort(eng_abort),
    .mb_ready(mb_ready), .mb_aborted(mb_aborted), .irq(irq)
  );

  // behavioural reference model
  int          m_mode [4];
  int          m_prio [4];
  logic [31:0] m_id   [4];
  logic [63:0] m_dat  [4];
  logic [3:0]  m_dlc  [4];
  logic        m_rtr  [4];
  logic [3:0]  m_pend, m_rdy, m_abf, m_irq;
  logic        m_busy, m_start;
  int          m_cur;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_mode[i] = 0; m_prio[i] = 0; m_id[i] = '0; m_dat[i] = '0;
        m_dlc[i] = '0; m_rtr[i] = 1'b0;
      end
      m_pend = '0; m_rdy = 4'hF; m_abf = '0; m_irq = '0;
      m_busy = 1'b0; m_start = 1'b0; m_cur = 0;
    end else begin
      int w;
      logic launch, fin;
      logic [3:0] irqn;
      w = -1;
      for (int i = 0; i < 4; i++)
        if (m_pend[i] && m_mode[i] == 3 && (w < 0 || m_prio[i] < m_prio[w])) w = i;
      launch = !m_busy && (w >= 0);
      fin = m_busy && (eng_done || eng_abort);
      irqn = '0;
      if (cfg_we) begin
        int m;
        m = int'(cfg_mb);
        case (cfg_sel)
          3'd0: begin m_mode[m] = int'(cfg_wdata[26:24]); m_prio[m] = int'(cfg_wdata[19:16]); end
          3'd1: if (m_mode[m] == 0) m_id[m] = cfg_wdata;
          3'd2: if (!m_pend[m]) m_dat[m][31:0] = cfg_wdata;
          3'd3: if (!m_pend[m]) m_dat[m][63:32] = cfg_wdata;
          3'd4: begin
            if (cfg_wdata[23] && m_mode[m] == 3 && m_rdy[m]) begin
              m_dlc[m] = cfg_wdata[19:16]; m_rtr[m] = cfg_wdata[20];
              m_pend[m] = 1'b1; m_rdy[m] = 1'b0; m_abf[m] = 1'b0;
            end else if (cfg_wdata[22] && m_pend[m] && !(m_busy && m_cur == m)
                         && !(launch && w == m)) begin
              m_pend[m] = 1'b0; m_rdy[m] = 1'b1; m_abf[m] = 1'b1; irqn[m] = 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (fin) begin
        m_pend[m_cur] = 1'b0; m_rdy[m_cur] = 1'b1; m_abf[m_cur] = eng_abort;
        irqn[m_cur] = 1'b1;
      end
      m_start = launch;
      if (launch) begin m_busy = 1'b1; m_cur = w; end
      else if (fin) m_busy = 1'b0;
      m_irq = irqn;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(mb_ready == m_rdy, "R2 ready", 64'(mb_ready), 64'(m_rdy));
      chk(mb_aborted == m_abf, "R8 aborted", 64'(mb_aborted), 64'(m_abf));
      chk(irq == {m_irq, 12'h000}, "R7 irq", 64'(irq), 64'({m_irq, 12'h000}));
      chk(eng_start == m_start, "R6 start", 64'(eng_start), 64'(m_start));
      if (m_start) begin
        chk(eng_mb == 2'(m_cur), "R3 winner", 64'(eng_mb), 64'(m_cur));
        chk(eng_id == m_id[m_cur], "R5 id", 64'(eng_id), 64'(m_id[m_cur]));
        chk(eng_dlc == m_dlc[m_cur], "R2 dlc", 64'(eng_dlc), 64'(m_dlc[m_cur]));
        chk(eng_rtr == m_rtr[m_cur], "R2 rtr", 64'(eng_rtr), 64'(m_rtr[m_cur]));
        chk(eng_data == m_dat[m_cur], "R11 data", eng_data, m_dat[m_cur]);
      end
    end
  end

  task automatic wr(input int m, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mb = 2'(m); cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int m, input int p, input logic [31:0] id, input logic [63:0] d);
    wr(m, 3'd0, 32'h0);
    wr(m, 3'd1, id);
    wr(m, 3'd0, (32'd3 << 24) | (32'(p) << 16));
    wr(m, 3'd2, d[31:0]);
    wr(m, 3'd3, d[63:32]);
  endtask

  task automatic req(input int m, input int dlc, input bit rtr);
    wr(m, 3'd4, (32'd1 << 23) | (32'(rtr) << 20) | (32'(dlc) << 16));
  endtask

  task automatic wait_start(output int mb);
    mb = -1;
    for (int k = 0; k < 40 && mb < 0; k++) begin
      @(negedge clk);
      if (eng_start) mb = int'(eng_mb);
    end
  endtask

  task automatic report(input bit ab);
    @(negedge clk);
    eng_done = !ab; eng_abort = ab;
    @(negedge clk);
    eng_done = 1'b0; eng_abort = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mb_ready == 4'hF, "R1 ready", 64'(mb_ready), 64'hF);
    chk(mb_aborted == 4'h0, "R1 aborted", 64'(mb_aborted), 64'h0);
    chk(irq == 16'h0 && !eng_start, "R1 irq/start", 64'(irq), 64'h0);

    // R2: request in disabled mode is ignored
    req(0, 8, 1'b0);
    repeat (3) @(negedge clk);
    chk(mb_ready[0] == 1'b1, "R2 ignored in disabled mode", 64'(mb_ready), 64'hF);

    setup(0, 3, 32'h0000_0A00, 64'h0011_2233_4455_6677);
    setup(1, 1, 32'h0000_0B11, 64'h1111_1111_1111_1111);
    setup(2, 1, 32'h0000_0C22, 64'h2222_2222_2222_2222);
    setup(3, 7, 32'h0000_0D33, 64'h3333_3333_3333_3333);

    req(3, 2, 1'b1);
    wait_start(mb);
    chk(mb == 3, "R3 only candidate", 64'(mb), 64'd3);
    chk(eng_rtr == 1'b1 && eng_dlc == 4'd2, "R2 dlc/rtr latched", 64'({eng_rtr, eng_dlc}), 64'h12);
    req(0, 8, 1'b0);
    req(2, 5, 1'b0);
    req(1, 4, 1'b0);
    chk(mb_ready == 4'h0, "R2 ready cleared", 64'(mb_ready), 64'h0);
    wr(0, 3'd1, 32'hDEAD_BEEF);   // R5: mode is transmit, ignored
    wr(0, 3'd2, 32'hFFFF_FFFF);   // R11: pending, ignored
    repeat (4) @(negedge clk);
    chk(eng_mb == 2'd3 && !eng_start, "R6 no preemption", 64'(eng_mb), 64'd3);

    report(1'b0);
    chk(irq[15] && mb_ready[3] && !mb_aborted[3], "R7 done irq15", 64'(irq), 64'h8000);
    wait_start(mb);
    chk(mb == 1, "R4 tie to lowest index", 64'(mb), 64'd1);
    report(1'b0);
    wait_start(mb);
    chk(mb == 2, "R4 second of tie", 64'(mb), 64'd2);
    report(1'b0);
    wait_start(mb);
    chk(mb == 0, "R3 worst priority last", 64'(mb), 64'd0);
    chk(eng_id == 32'h0000_0A00, "R5 id write ignored", 64'(eng_id), 64'hA00);
    chk(eng_data == 64'h0011_2233_4455_6677, "R11 data write ignored", eng_data, 64'h0011_2233_4455_6677);

    // R9: cancel queued mailbox, cancel of in-flight ignored
    req(1, 1, 1'b0);
    req(2, 1, 1'b0);
    wr(2, 3'd4, 32'd1 << 22);
    chk(mb_aborted[2] && mb_ready[2] && irq[14], "R9 cancel queued", 64'({irq[14], mb_ready[2], mb_aborted[2]}), 64'h7);
    wr(0, 3'd4, 32'd1 << 22);
    chk(!mb_ready[0] && !mb_aborted[0], "R9 in-flight not cancelled", 64'({mb_ready[0], mb_aborted[0]}), 64'h0);

    // R8: engine abort
    report(1'b1);
    chk(mb_aborted[0] && mb_ready[0] && irq[12], "R8 engine abort", 64'({irq[12], mb_ready[0], mb_aborted[0]}), 64'h7);
    wait_start(mb);
    chk(mb == 1, "R9 cancelled mailbox skipped", 64'(mb), 64'd1);
    report(1'b0);

    // R10: new request clears aborted flag
    req(0, 3, 1'b0);
    chk(!mb_aborted[0], "R10 abort cleared", 64'(mb_aborted), 64'h0);
    wait_start(mb);
    chk(mb == 0, "R10 resend", 64'(mb), 64'd0);
    report(1'b0);
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule